// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit sits inside a CPU debug engine and decides when the running user program should be stopped. It holds six 16-bit breakpoint registers. The four low-numbered ones watch the instruction fetch address. The two high-numbered ones each have a mode bit. In one mode they watch the data memory address. In the other mode they watch the module/index code that the CPU presents when it touches an internal register. A match counts only on a cycle where the matching bus carries its valid strobe, and only while the debug-enable input is high. The unit then raises a one-cycle break request along with the number of the lowest matching register.

The breakpoint registers and the mode bits are reached only through a small debug command port, which has a select field, write data, a write strobe and a read strobe. The CPU buses carry no path that can change them. Both a power-on reset and the TAP test-logic-reset state return every breakpoint register to all ones and both mode bits to data mode. The debug command decoder, the TAP and the CPU's entry into debug mode sit outside this block.

Top module: `bkpt_match_unit`

## Requirements
- R1: After `rst_n` is released, every breakpoint register reads 16'hFFFF and the mode word (select 6) reads 0.
- R2: A cycle with `tlr` high returns all six breakpoint registers to 16'hFFFF and both mode bits to 0. Such a cycle takes precedence over a debug write in the same cycle.
- R3: A debug write with `dbg_sel` 0..5 stores `dbg_wdata` in that register. A read with `dbg_rd_en` presents the selected value on `dbg_rdata` one clock later.
- R4: When `fetch_valid` is high and `fetch_addr` equals one of BP0..BP3 while `dme` is high, `brk_req` is high in the next cycle for exactly that cycle, and `brk_idx` holds the register number.
- R5: While `dme` is low, no bus activity produces `brk_req`.
- R6: A cycle with `fetch_valid`, `data_valid` and `regacc_valid` all low produces no break, whatever the address buses carry.
- R7: BP4/BP5 in data mode (mode bit 0) break when `data_valid` is high and all 16 bits of `data_addr` equal the register.
- R8: BP4/BP5 in register mode (mode bit 1) break when `regacc_valid` is high and `regacc_code` equals the register's low 8 bits. In this mode, data accesses to the same value do not break.
- R9: When several registers match in one cycle, `brk_idx` reports the lowest-numbered one.
- R10: Select 6 holds the mode bits: bit 0 is for BP4 and bit 1 is for BP5, and the bits are written from `dbg_wdata[1:0]`. Select 7 reads as 0, and writes to select 7 change no register.
- R11: BP0..BP3 never respond to data or register accesses, and BP4/BP5 never respond to fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tlr | input | 1 | TAP in test-logic-reset; synchronous reset of the breakpoint state |
| dme | input | 1 | Debug-mode enable; breaks are generated only while it is high |
| dbg_sel | input | 3 | Debug command select: 0..5 breakpoint, 6 mode word |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rd_en | input | 1 | Debug read strobe |
| dbg_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 16 | Program fetch address |
| data_valid | input | 1 | Data memory access strobe |
| data_addr | input | 16 | Data memory address |
| regacc_valid | input | 1 | Register access strobe |
| regacc_code | input | 8 | Module/index code of the accessed register |
| brk_req | output | 1 | Registered one-cycle break request |
| brk_idx | output | 3 | Lowest matching breakpoint number |

## Verification
The hardest cases to reach from the ports are cycles where several comparators fire at once and the priority order decides the reported index. The same holds for a high-register value that is offered on the wrong bus for its current mode. The stimulus loads two program registers with equal values and places BP5 in register mode with a non-zero upper byte. A vector table then drives simultaneous fetch and data hits, data accesses that equal BP5 exactly, and codes that match only its low byte. Directed steps then clear `dme` and assert `tlr`, and read every register back.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   typedef enum logic {
      BK_MODE_DATA = 1'b0,
      BK_MODE_REG  = 1'b1
   } bk_mode_e;
endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile #(
   parameter int ADDR_W   = 16,
   parameter int NUM_PROG = 4,
   parameter int NUM_DATA = 2,
   parameter int SEL_W    = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 tlr,
   input  logic [SEL_W-1:0]                     sel,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wdata,
   input  logic                                 rd_en,
   output logic [ADDR_W-1:0]                    rdata,
   output logic [NUM_PROG+NUM_DATA-1:0][ADDR_W-1:0] bp_q,
   output logic [NUM_DATA-1:0]                  mode_q
);
   localparam int NUM_BP   = NUM_PROG + NUM_DATA;
   localparam int MODE_SEL = NUM_BP;

   if (NUM_DATA > ADDR_W) begin : g_chk_mode
      $error("mode word does not fit in the data width");
   end

   for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bp_q[i] <= '1;
         else if (tlr)
            bp_q[i] <= '1;
         else if (wr_en && sel == SEL_W'(i))
            bp_q[i] <= wdata;
      end

      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !tlr && sel == SEL_W'(i)) |=> bp_q[i] == $past(wdata));
      a_r2_tlr_sets_ones: assert property (@(posedge clk) disable iff (!rst_n)
         tlr |=> bp_q[i] == '1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= '0;
      else if (tlr)
         mode_q <= '0;
      else if (wr_en && sel == SEL_W'(MODE_SEL))
         mode_q <= wdata[NUM_DATA-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en) begin
         if (int'(sel) < NUM_BP)
            rdata <= bp_q[sel];
         else if (int'(sel) == MODE_SEL)
            rdata <= ADDR_W'(mode_q);
         else
            rdata <= '0;
      end
   end

   a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!tlr && !(wr_en && sel == SEL_W'(MODE_SEL))) |=> $stable(mode_q));
endmodule

// File: rtl/bkpt_compare.sv
module bkpt_compare
   import bkpt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int NUM_PROG = 4,
   parameter int NUM_DATA = 2,
   parameter int CODE_W   = 8
) (
   input  logic [NUM_PROG+NUM_DATA-1:0][ADDR_W-1:0] bp_q,
   input  logic [NUM_DATA-1:0]                  mode_q,
   input  logic                                 fetch_valid,
   input  logic [ADDR_W-1:0]                    fetch_addr,
   input  logic                                 data_valid,
   input  logic [ADDR_W-1:0]                    data_addr,
   input  logic                                 regacc_valid,
   input  logic [CODE_W-1:0]                    regacc_code,
   output logic [NUM_PROG+NUM_DATA-1:0]         hits
);
   localparam int NUM_BP = NUM_PROG + NUM_DATA;

   if (CODE_W > ADDR_W) begin : g_chk_code
      $error("register code wider than breakpoint register");
   end

   for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
      if (i < NUM_PROG) begin : g_prog
         assign hits[i] = fetch_valid && (fetch_addr == bp_q[i]);
      end else begin : g_dual
         bk_mode_e mode;
         assign mode = bk_mode_e'(mode_q[i-NUM_PROG]);
         always_comb begin
            if (mode == BK_MODE_REG)
               hits[i] = regacc_valid && (regacc_code == bp_q[i][CODE_W-1:0]);
            else
               hits[i] = data_valid && (data_addr == bp_q[i]);
         end
      end
   end
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit #(
   parameter int ADDR_W   = 16,
   parameter int NUM_PROG = 4,
   parameter int NUM_DATA = 2,
   parameter int CODE_W   = 8,
   parameter int SEL_W    = $clog2(NUM_PROG + NUM_DATA + 1),
   parameter int IDX_W    = $clog2(NUM_PROG + NUM_DATA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tlr,
   input  logic              dme,
   input  logic [SEL_W-1:0]  dbg_sel,
   input  logic              dbg_wr_en,
   input  logic [ADDR_W-1:0] dbg_wdata,
   input  logic              dbg_rd_en,
   output logic [ADDR_W-1:0] dbg_rdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic              regacc_valid,
   input  logic [CODE_W-1:0] regacc_code,
   output logic              brk_req,
   output logic [IDX_W-1:0]  brk_idx
);
   localparam int NUM_BP = NUM_PROG + NUM_DATA;

   if (2**SEL_W < NUM_BP + 1) begin : g_chk_sel
      $error("select field too narrow");
   end
   if (2**IDX_W < NUM_BP) begin : g_chk_idx
      $error("index field too narrow");
   end

   logic [NUM_BP-1:0][ADDR_W-1:0] bp_q;
   logic [NUM_DATA-1:0]           mode_q;
   logic [NUM_BP-1:0]             hits;
   logic [IDX_W-1:0]              first_idx;

   bkpt_regfile #(.ADDR_W(ADDR_W), .NUM_PROG(NUM_PROG), .NUM_DATA(NUM_DATA),
                  .SEL_W(SEL_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .tlr(tlr), .sel(dbg_sel), .wr_en(dbg_wr_en),
      .wdata(dbg_wdata), .rd_en(dbg_rd_en), .rdata(dbg_rdata),
      .bp_q(bp_q), .mode_q(mode_q));

   bkpt_compare #(.ADDR_W(ADDR_W), .NUM_PROG(NUM_PROG), .NUM_DATA(NUM_DATA),
                  .CODE_W(CODE_W)) cmp_i (
      .bp_q(bp_q), .mode_q(mode_q), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .data_valid(data_valid), .data_addr(data_addr),
      .regacc_valid(regacc_valid), .regacc_code(regacc_code), .hits(hits));

   always_comb begin
      first_idx = '0;
      for (int i = NUM_BP - 1; i >= 0; i--)
         if (hits[i]) first_idx = IDX_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req <= 1'b0;
         brk_idx <= '0;
      end else begin
         brk_req <= dme && (|hits);
         brk_idx <= (dme && (|hits)) ? first_idx : '0;
      end
   end

   a_r5_no_brk_without_dme: assert property (@(posedge clk) disable iff (!rst_n)
      !dme |=> !brk_req);
   a_r6_idle_no_brk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_valid || data_valid || regacc_valid) |=> !brk_req);
   a_r9_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> int'(brk_idx) < NUM_BP);
   a_r9_lowest_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (dme && hits[0]) |=> brk_req && brk_idx == '0);
   a_r11_prog_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> hits[NUM_PROG-1:0] == '0);
endmodule

// File: tb/bkpt_match_unit_tb_top.sv
module bkpt_match_unit_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tlr = 1'b0, dme = 1'b0;
   logic [2:0]  dbg_sel = '0;
   logic        dbg_wr_en = 1'b0, dbg_rd_en = 1'b0;
   logic [15:0] dbg_wdata = '0;
   logic [15:0] dbg_rdata;
   logic        fetch_valid = 1'b0, data_valid = 1'b0, regacc_valid = 1'b0;
   logic [15:0] fetch_addr = '0, data_addr = '0;
   logic [7:0]  regacc_code = '0;
   logic        brk_req;
   logic [2:0]  brk_idx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bkpt_match_unit dut_i (
      .clk(clk), .rst_n(rst_n), .tlr(tlr), .dme(dme), .dbg_sel(dbg_sel),
      .dbg_wr_en(dbg_wr_en), .dbg_wdata(dbg_wdata), .dbg_rd_en(dbg_rd_en),
      .dbg_rdata(dbg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .data_valid(data_valid), .data_addr(data_addr),
      .regacc_valid(regacc_valid), .regacc_code(regacc_code),
      .brk_req(brk_req), .brk_idx(brk_idx));

   // vector: fv, faddr, dv, daddr, rv, rcode, exp_req, exp_idx (47 bits)
   localparam int NV = 11;
   localparam logic [46:0] VEC [NV] = '{
      {1'b1,16'h1000, 1'b0,16'h0000, 1'b0,8'h00, 1'b1,3'd0}, // R4
      {1'b1,16'h2000, 1'b0,16'h0000, 1'b0,8'h00, 1'b1,3'd1}, // R9 BP1=BP2
      {1'b1,16'h3000, 1'b0,16'h0000, 1'b0,8'h00, 1'b1,3'd3}, // R4
      {1'b1,16'h4000, 1'b0,16'h0000, 1'b0,8'h00, 1'b0,3'd0}, // R11
      {1'b0,16'h0000, 1'b1,16'h4000, 1'b0,8'h00, 1'b1,3'd4}, // R7
      {1'b0,16'h0000, 1'b1,16'h1000, 1'b0,8'h00, 1'b0,3'd0}, // R11
      {1'b0,16'h0000, 1'b0,16'h0000, 1'b1,8'h55, 1'b1,3'd5}, // R8
      {1'b0,16'h0000, 1'b1,16'hAB55, 1'b0,8'h00, 1'b0,3'd0}, // R8
      {1'b0,16'h1000, 1'b0,16'h4000, 1'b0,8'h55, 1'b0,3'd0}, // R6
      {1'b1,16'h3000, 1'b1,16'h4000, 1'b0,8'h00, 1'b1,3'd3}, // R9
      {1'b0,16'h0000, 1'b1,16'h4001, 1'b1,8'h54, 1'b0,3'd0}  // R7
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      dbg_sel = s; dbg_wdata = d; dbg_wr_en = 1'b1;
      @(negedge clk);
      dbg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] d);
      dbg_sel = s; dbg_rd_en = 1'b1;
      @(negedge clk);
      dbg_rd_en = 1'b0;
      d = dbg_rdata;
   endtask

   task automatic bus(input logic fv, input logic [15:0] fa, input logic dv,
                      input logic [15:0] da, input logic rv, input logic [7:0] rc);
      fetch_valid = fv; fetch_addr = fa; data_valid = dv; data_addr = da;
      regacc_valid = rv; regacc_code = rc;
      @(negedge clk);
      fetch_valid = 1'b0; data_valid = 1'b0; regacc_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(brk_req == 1'b0, "R1 brk_req", 32'(brk_req), 32'd0);
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         check(v == 16'hFFFF, "R1 bp reset", 32'(v), 32'hFFFF);
      end
      rd(3'd6, v);
      check(v == 16'h0000, "R1 mode reset", 32'(v), 32'h0);

      wr(3'd0, 16'h1000); wr(3'd1, 16'h2000); wr(3'd2, 16'h2000);
      wr(3'd3, 16'h3000); wr(3'd4, 16'h4000); wr(3'd5, 16'hAB55);
      wr(3'd6, 16'h0002);
      rd(3'd2, v);
      check(v == 16'h2000, "R3 readback", 32'(v), 32'h2000);
      rd(3'd5, v);
      check(v == 16'hAB55, "R3 readback", 32'(v), 32'hAB55);
      rd(3'd6, v);
      check(v == 16'h0002, "R10 mode word", 32'(v), 32'h2);

      dme = 1'b1;
      for (int k = 0; k < NV; k++) begin
         logic [46:0] e;
         e = VEC[k];
         bus(e[46], e[45:30], e[29], e[28:13], e[12], e[11:4]);
         check(brk_req == e[3], "R4/R7/R8/R9/R11 req", 32'(brk_req), 32'(e[3]));
         if (e[3])
            check(brk_idx == e[2:0], "R9 idx", 32'(brk_idx), 32'(e[2:0]));
         @(negedge clk);
         check(brk_req == 1'b0, "R4 single pulse", 32'(brk_req), 32'd0);
      end

      dme = 1'b0;
      bus(1'b1, 16'h1000, 1'b1, 16'h4000, 1'b1, 8'h55);
      check(brk_req == 1'b0, "R5 dme low", 32'(brk_req), 32'd0);
      dme = 1'b1;

      bus(1'b0, 16'h0000, 1'b1, 16'h1000, 1'b1, 8'h00);
      rd(3'd0, v);
      check(v == 16'h1000, "R11 cpu access no change", 32'(v), 32'h1000);

      wr(3'd7, 16'h0001);
      rd(3'd7, v);
      check(v == 16'h0000, "R10 sel7 reads 0", 32'(v), 32'h0);
      rd(3'd6, v);
      check(v == 16'h0002, "R10 sel7 write ignored", 32'(v), 32'h2);
      rd(3'd0, v);
      check(v == 16'h1000, "R10 sel7 write ignored", 32'(v), 32'h1000);

      // BP4 to register mode: data access to 0x4000 no longer breaks
      wr(3'd6, 16'h0003);
      bus(1'b0, 16'h0000, 1'b1, 16'h4000, 1'b0, 8'h00);
      check(brk_req == 1'b0, "R8 data ignored in reg mode", 32'(brk_req), 32'd0);
      bus(1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'h00);
      check(brk_req == 1'b1 && brk_idx == 3'd4, "R8 bp4 reg code",
            {brk_req, 28'd0, brk_idx}, {1'b1, 28'd0, 3'd4});

      // tlr beats a simultaneous write
      tlr = 1'b1; dbg_sel = 3'd0; dbg_wdata = 16'h1234; dbg_wr_en = 1'b1;
      @(negedge clk);
      tlr = 1'b0; dbg_wr_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         check(v == 16'hFFFF, "R2 tlr ones", 32'(v), 32'hFFFF);
      end
      rd(3'd6, v);
      check(v == 16'h0000, "R2 tlr mode", 32'(v), 32'h0);
      bus(1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 8'h00);
      check(brk_req == 1'b1 && brk_idx == 3'd0, "R2 ones match fetch",
            {brk_req, 28'd0, brk_idx}, {1'b1, 28'd0, 3'd0});

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule